// File: doc/BRIEF.md
# Two-Bank Byte-Addressed GPIO Controller

This block is a general-purpose pin controller reached over a plain 8-bit register bus with separate read and write strobes. It owns a parameterised number of pins, numbered globally, and splits them at index `SPLIT` into a core bank (pins below the split) and a resume bank (pins at or above it, renumbered from zero). Each bank carries three register groups: a pin-enable group, a direction group and a level group, each up to four bytes wide.

Software enables a pin, chooses its direction, and then reads or drives its level. A pad is driven only when the pin is enabled and set as output. While a pin is an input its level bit is read-only, so the output value cannot be staged before the pin is turned around; the host switches the pin to output first and then writes the level. Pad inputs cross a two-flop synchronizer before they become visible in level reads.

Top module: `gpio2b_ctrl`

## Requirements
- R1: Pins below `SPLIT` map to the core bank at base 0x00; pins from `SPLIT` upward map to the resume bank at base 0x20 and are renumbered from 0. Within a bank, enable bytes sit at offset 0x00..0x03, direction bytes at 0x04..0x07, level bytes at 0x08..0x0B; local pin n is in byte n/8 of its group, at bit n mod 8.
- R2: After reset the enable bits equal the parameter `EN_DEFAULT` (default 0x1C7F: core pins 0..6 and resume pins 0..2), every direction bit is 1, every stored level is 0, and `pad_oe` is all zero.
- R3: A direction bit of 1 means input, 0 means output; `pad_oe` of a pin is 1 exactly when its enable bit is 1 and its direction bit is 0, and `pad_out` carries the stored level.
- R4: A write to a level byte changes only bits whose pin is an output at the time of the write; bits of input pins keep their stored value, so no level can be preset before the pin becomes an output.
- R5: A level read returns the synchronized pad value for input pins and the stored level for output pins.
- R6: A pad change present at clock edge k is returned by a level read whose strobe is sampled at edge k+2 or later, and not by one sampled at edge k or k+1.
- R7: Read data appears on `rd_data` in the cycle after the read strobe is sampled; in a cycle not preceded by a sampled read strobe, `rd_data` is 0.
- R8: Addresses outside R1's groups (including 0x0C..0x1F, 0x2C..0x3F, 0x40 and above) and bytes or bits for pins that do not exist read as 0 and ignore writes.
- R9: A read and a write to the same address in the same cycle return the value held before that write.
- R10: A write to an enable or direction byte replaces the bits of every existing pin in that byte in one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid one cycle after the strobe |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad output levels |

## Verification
The register path is driven with random writes and reads across the whole 0x00..0x3F window plus addresses above it, interleaved with random pad input changes, so the model sees enable, direction and level bytes land in both banks with every mix of input and output pins; this separates the bank split and renumbering from plain byte indexing. Directed cases attempt a level preset on all-input pins, write a level byte with half the pins as inputs, probe the synchronizer latency edge by edge, read bytes for absent pins, and collide a read with a write on one address, each telling apart a specific masking or timing rule from a near miss.

// File: rtl/gpio2b_pkg.sv
package gpio2b_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int MAX_BYTES = 4;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_EN,
        RK_DIR,
        RK_LVL
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic      resume;
        reg_kind_e kind;
        logic [1:0] byte_idx;
    } reg_sel_t;

    // Bytes needed to hold n pin bits.
    function automatic int bytes_for(input int n);
        return (n + 7) / 8;
    endfunction

    // Split a bus address into bank, register group and byte index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s          = '0;
        s.kind     = RK_NONE;
        if (a[7:6] == 2'b00 && a[4] == 1'b0) begin
            s.resume   = a[5];
            s.byte_idx = a[1:0];
            case (a[3:2])
                2'b00:   s.kind = RK_EN;
                2'b01:   s.kind = RK_DIR;
                2'b10:   s.kind = RK_LVL;
                default: s.kind = RK_NONE;
            endcase
            s.hit = (s.kind != RK_NONE);
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio2b_sync.sv
module gpio2b_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    // R6: synchronized value trails the pad by exactly two edges
    assert_sync_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio2b_bank.sv
module gpio2b_bank
    import gpio2b_pkg::*;
#(
    parameter int            NPIN   = 8,
    parameter logic [NPIN-1:0] EN_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_t         sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPIN-1:0]  pin_sync,
    output logic [DATA_W-1:0] rdata,
    output logic [NPIN-1:0]  en_o,
    output logic [NPIN-1:0]  dir_o,
    output logic [NPIN-1:0]  lvl_o
);

    localparam int NBYTES = bytes_for(NPIN);

    logic [NPIN-1:0] en_q;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] lvl_q;
    logic            byte_ok;

    assign byte_ok = sel.hit && (int'(sel.byte_idx) < NBYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= EN_RST;
            dir_q <= '1;
            lvl_q <= '0;
        end else if (wr && byte_ok) begin
            for (int i = 0; i < NPIN; i++) begin
                if (i[4:3] == sel.byte_idx) begin
                    case (sel.kind)
                        RK_EN:  en_q[i]  <= wdata[i[2:0]];
                        RK_DIR: dir_q[i] <= wdata[i[2:0]];
                        RK_LVL: if (!dir_q[i]) lvl_q[i] <= wdata[i[2:0]];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (byte_ok) begin
            for (int i = 0; i < NPIN; i++) begin
                if (i[4:3] == sel.byte_idx) begin
                    case (sel.kind)
                        RK_EN:   rdata[i[2:0]] = en_q[i];
                        RK_DIR:  rdata[i[2:0]] = dir_q[i];
                        RK_LVL:  rdata[i[2:0]] = dir_q[i] ? pin_sync[i] : lvl_q[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    assign en_o  = en_q;
    assign dir_o = dir_q;
    assign lvl_o = lvl_q;

    // R4: stored level of a pin that was an input never moves
    assert_lvl_locked_on_input_R4: assert property (@(posedge clk) disable iff (rst)
        ((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0);

    // R2: state seen right after reset matches the defaults
    assert_reset_state_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == EN_RST && dir_q == '1 && lvl_q == '0));

endmodule

// File: rtl/gpio2b_ctrl.sv
module gpio2b_ctrl
    import gpio2b_pkg::*;
#(
    parameter int                  NUM_PINS   = 14,
    parameter int                  SPLIT      = 10,
    parameter logic [NUM_PINS-1:0] EN_DEFAULT = 14'h1C7F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);

    localparam int CORE_N = SPLIT;
    localparam int RES_N  = NUM_PINS - SPLIT;

    reg_sel_t sel;
    reg_sel_t core_sel;
    reg_sel_t res_sel;

    logic [NUM_PINS-1:0] pin_sync;
    logic [DATA_W-1:0]   core_rd;
    logic [DATA_W-1:0]   res_rd;
    logic [DATA_W-1:0]   rd_q;

    logic [CORE_N-1:0] core_en, core_dir, core_lvl;
    logic [RES_N-1:0]  res_en, res_dir, res_lvl;

    always_comb begin
        sel          = decode_addr(addr);
        core_sel     = sel;
        core_sel.hit = sel.hit & ~sel.resume;
        res_sel      = sel;
        res_sel.hit  = sel.hit & sel.resume;
    end

    gpio2b_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio2b_bank #(
        .NPIN   (CORE_N),
        .EN_RST (EN_DEFAULT[CORE_N-1:0])
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_en),
        .sel      (core_sel),
        .wdata    (wr_data),
        .pin_sync (pin_sync[CORE_N-1:0]),
        .rdata    (core_rd),
        .en_o     (core_en),
        .dir_o    (core_dir),
        .lvl_o    (core_lvl)
    );

    gpio2b_bank #(
        .NPIN   (RES_N),
        .EN_RST (EN_DEFAULT[NUM_PINS-1:SPLIT])
    ) u_resume (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_en),
        .sel      (res_sel),
        .wdata    (wr_data),
        .pin_sync (pin_sync[NUM_PINS-1:SPLIT]),
        .rdata    (res_rd),
        .en_o     (res_en),
        .dir_o    (res_dir),
        .lvl_o    (res_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= core_rd | res_rd;
        end else begin
            rd_q <= '0;
        end
    end

    assign rd_data = rd_q;
    assign pad_oe  = {res_en & ~res_dir, core_en & ~core_dir};
    assign pad_out = {res_lvl, core_lvl};

    // R7: no read strobe in the previous cycle leaves the read bus at zero
    assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rd_data == '0));

    // R8: a read of an undecoded address returns zero
    assert_undecoded_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(sel.hit)) |-> (rd_data == '0));

    // R3: a pin whose direction was just written to input stops driving
    assert_dir_input_releases_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(sel.hit) && $past(sel.kind) == RK_DIR
         && !$past(sel.resume) && $past(sel.byte_idx) == 2'b00 && $past(wr_data) == 8'hFF)
        |-> (pad_oe[0] == 1'b0));

endmodule

// File: tb/gpio2b_ctrl_tb.sv
module gpio2b_ctrl_tb;

    localparam int   CLK_PERIOD = 10;
    localparam int   NP = 14;
    localparam int   SP = 10;
    localparam logic [NP-1:0] EN_DEF = 14'h1C7F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int total = 0;
    int bad   = 0;

    logic [NP-1:0] en_m, dir_m, lvl_m;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio2b_ctrl #(.NUM_PINS(NP), .SPLIT(SP), .EN_DEFAULT(EN_DEF)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pad_in  (pad_in),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] r;
        int base, n, g;
        r = '0;
        if (a[7:6] == 2'b00 && a[4] == 1'b0 && a[3:2] != 2'b11) begin
            base = a[5] ? SP : 0;
            n    = a[5] ? NP - SP : SP;
            for (int i = 0; i < n; i++) begin
                if (i / 8 == int'(a[1:0])) begin
                    g = base + i;
                    case (a[3:2])
                        2'b00:   r[i % 8] = en_m[g];
                        2'b01:   r[i % 8] = dir_m[g];
                        default: r[i % 8] = dir_m[g] ? pad_in[g] : lvl_m[g];
                    endcase
                end
            end
        end
        return r;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        int base, n, g;
        if (a[7:6] == 2'b00 && a[4] == 1'b0 && a[3:2] != 2'b11) begin
            base = a[5] ? SP : 0;
            n    = a[5] ? NP - SP : SP;
            for (int i = 0; i < n; i++) begin
                if (i / 8 == int'(a[1:0])) begin
                    g = base + i;
                    case (a[3:2])
                        2'b00:   en_m[g]  = d[i % 8];
                        2'b01:   dir_m[g] = d[i % 8];
                        default: if (!dir_m[g]) lvl_m[g] = d[i % 8];
                    endcase
                end
            end
        end
    endtask

    task automatic check_pads(input string req);
        chk({req, " pad_oe"},  32'(pad_oe),  32'(en_m & ~dir_m));
        chk({req, " pad_out"}, 32'(pad_out), 32'(lvl_m));
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, 32'(rd_data), 32'(model_read(a)));
    endtask

    task automatic set_pads(input logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        int op;
        void'($urandom(32'h5EED_0123));
        en_m  = EN_DEF;
        dir_m = '1;
        lvl_m = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset defaults, checked with literal values
        chk("R2 pad_oe", 32'(pad_oe), 32'h0);
        chk("R2 pad_out", 32'(pad_out), 32'h0);
        chk("R7 idle rd_data", 32'(rd_data), 32'h0);
        @(negedge clk); addr = 8'h00; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; chk("R2 core en0", 32'(rd_data), 32'h7F);
        @(negedge clk); chk("R7 rd_data back to zero", 32'(rd_data), 32'h0);
        bus_read(8'h01, "R2 core en1");
        bus_read(8'h20, "R2 resume en0");
        bus_read(8'h04, "R2 core dir0");
        bus_read(8'h05, "R2 core dir1");
        bus_read(8'h24, "R2 resume dir0");

        // R6: synchronizer latency, edge by edge
        @(negedge clk);
        pad_in[7:0] = 8'hA5; addr = 8'h08; rd_en = 1'b1;
        @(negedge clk); chk("R6 edge k", 32'(rd_data), 32'h00);
        @(negedge clk); chk("R6 edge k+1", 32'(rd_data), 32'h00);
        @(negedge clk); chk("R6 edge k+2", 32'(rd_data), 32'hA5);
        rd_en = 1'b0;
        set_pads('0);

        // R4: preset attempt on all-input pins is dropped
        bus_write(8'h08, 8'hFF);
        bus_write(8'h04, 8'h00);
        chk("R4 no preset pad_out", 32'(pad_out[7:0]), 32'h00);
        bus_read(8'h08, "R5 output pins read stored level");
        bus_write(8'h08, 8'hFF);
        chk("R3 pad_out follows level", 32'(pad_out[7:0]), 32'hFF);
        chk("R3 pad_oe enabled outputs", 32'(pad_oe[7:0]), 32'h7F);
        bus_write(8'h04, 8'hF0);
        bus_write(8'h08, 8'h00);
        chk("R4 mixed byte", 32'(pad_out[7:0]), 32'hF0);
        set_pads(14'h00AA);
        bus_read(8'h08, "R5 mixed level read");

        // R9: read and write on one address in one cycle
        @(negedge clk);
        addr = 8'h00; wr_data = 8'h00; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R9 prior value", 32'(rd_data), 32'h7F);
        model_write(8'h00, 8'h00);
        bus_read(8'h00, "R9 new value");

        // R10 / R8: full byte with absent pins
        bus_write(8'h01, 8'hFF);
        @(negedge clk); addr = 8'h01; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; chk("R10 R8 core en1 two pins", 32'(rd_data), 32'h03);
        bus_write(8'h20, 8'hFF);
        @(negedge clk); addr = 8'h20; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; chk("R1 R8 resume en0 four pins", 32'(rd_data), 32'h0F);

        // R1: resume pin 0 is global pin SPLIT
        bus_write(8'h24, 8'h0E);
        chk("R1 resume pin0 drives", 32'(pad_oe[SP]), 32'h1);
        check_pads("R1");

        // R8: undecoded and absent bytes
        bus_write(8'h41, 8'h00);
        bus_write(8'h0C, 8'hFF);
        bus_write(8'h03, 8'hFF);
        foreach (u_dut.pad_oe[k]) if (k == 0) check_pads("R8 ignored writes");
        @(negedge clk); addr = 8'h48; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; chk("R8 addr 0x48", 32'(rd_data), 32'h00);
        @(negedge clk); addr = 8'h0C; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; chk("R8 addr 0x0C", 32'(rd_data), 32'h00);
        @(negedge clk); addr = 8'h21; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; chk("R8 addr 0x21", 32'(rd_data), 32'h00);
        bus_read(8'h01, "R8 core en1 untouched");

        // Random mix, R1 R3 R4 R5 R10 against the bench model
        for (int it = 0; it < 600; it++) begin
            op = int'($urandom % 4);
            a  = 8'($urandom % 64);
            if ($urandom % 8 == 0) a = a | 8'h40;
            d  = 8'($urandom);
            case (op)
                0, 1: begin
                    bus_write(a, d);
                    check_pads("R3 R4 R10 random write");
                end
                2: bus_read(a, "R1 R5 random read");
                default: set_pads(NP'($urandom));
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule